// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a 32-bit word-wide data memory and the register file of a load-store processor. On a store, it takes the register value and the two low address bits. It drives a 4-bit byte-enable mask and a store word whose enabled lanes carry the value. On a load, it picks the addressed byte or halfword out of the returned memory word, or takes the whole word, and sign- or zero-extends the result to 32 bits. Lane mapping is big-endian: byte offset 0 is the most significant byte of the word.

Accesses that break natural alignment raise a misalign flag and do not complete. Unaligned word loads use a pair of merge loads. The left merge fills the high part of the destination from the addressed bytes. The right merge fills the low part. Each one keeps the rest of the old register value, which the caller supplies. The unit is purely combinational, so all outputs follow the inputs in the same cycle as the request.

Top module: `lsu_lane_unit`

## Requirements
- R1: The operation code `op_i` is 0=byte load signed, 1=byte load unsigned, 2=halfword load signed, 3=halfword load unsigned, 4=word load, 5=left merge load, 6=right merge load, 8=byte store, 9=halfword store, 10=word store. Any other code drives zero on `be_o`, `st_data_o` and `ld_data_o`, and keeps `misalign_o` low.
- R2: `misalign_o` is high exactly when a word load or word store has `off_i != 0`, or when a halfword load or halfword store has `off_i[0] == 1`. Byte accesses and merge loads never raise it.
- R3: A byte store at offset k sets only `be_o` bit (3-k) and drives the low data byte in all four lanes of `st_data_o`.
- R4: An aligned halfword store drives `be_o` = 4'b1100 at offset 0 and 4'b0011 at offset 2. It replicates the low 16 data bits into both halves of `st_data_o`.
- R5: A word store at offset 0 drives `be_o` = 4'b1111 and `st_data_o` = `st_data_i`.
- R6: A misaligned store drives `be_o` = 0.
- R7: A byte load at offset k returns memory bits [31-8k:24-8k]. The signed load sign-extends this byte and the unsigned load zero-extends it.
- R8: An aligned halfword load returns bits [31:16] at offset 0 and bits [15:0] at offset 2. The signed load sign-extends the value and the unsigned load zero-extends it.
- R9: An aligned word load returns the memory word unchanged. A misaligned halfword or word load returns 0.
- R10: A left merge load at offset k places memory bytes k..3 in the top 4-k bytes of `ld_data_o` and takes the low k bytes from `rd_old_i`.
- R11: A right merge load at offset k places memory bytes 0..k in the low k+1 bytes of `ld_data_o` and takes the high 3-k bytes from `rd_old_i`.
- R12: Load operations drive `be_o` = 0 and `st_data_o` = 0. Store operations drive `ld_data_o` = 0.
- R13: A left merge at unaligned address A followed by a right merge at A+3 yields the four bytes at A..A+3 in big-endian order. The second merge uses the first one's result as `rd_old_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1) |
| off_i | input | 2 | Byte offset within the word (address bits [1:0]) |
| st_data_i | input | 32 | Register value to store |
| mem_rdata_i | input | 32 | Word returned by the data memory |
| rd_old_i | input | 32 | Current destination register value for merge loads |
| be_o | output | 4 | Store byte enables, bit 3 is offset 0 |
| st_data_o | output | 32 | Lane-placed store data |
| ld_data_o | output | 32 | Extended or merged load result |
| misalign_o | output | 1 | Access is misaligned and must not complete |

## Verification
The hardest case to reach from the ports is the two-step unaligned word reconstruction. Each step is correct alone, but the pair only works if the byte counts of the left and right merges add up to exactly four at every offset. The bench chains the two merges on two distinct memory words. It feeds the first result back as `rd_old_i` and starts from a garbage register value, so that any leftover old byte shows up. It does this at all three unaligned offsets. The merge tests also use an old value whose bytes all differ from the memory bytes, so that a misplaced keep-or-replace boundary is visible.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int BYTE_W = 8;
  localparam int NBYTES = 4;
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int OFF_W  = $clog2(NBYTES);
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_LB  = 4'd0;
  localparam logic [OP_W-1:0] OP_LBU = 4'd1;
  localparam logic [OP_W-1:0] OP_LH  = 4'd2;
  localparam logic [OP_W-1:0] OP_LHU = 4'd3;
  localparam logic [OP_W-1:0] OP_LW  = 4'd4;
  localparam logic [OP_W-1:0] OP_LWL = 4'd5;
  localparam logic [OP_W-1:0] OP_LWR = 4'd6;
  localparam logic [OP_W-1:0] OP_SB  = 4'd8;
  localparam logic [OP_W-1:0] OP_SH  = 4'd9;
  localparam logic [OP_W-1:0] OP_SW  = 4'd10;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} size_e;

  typedef struct packed {
    logic  is_load;
    logic  is_store;
    logic  merge_l;
    logic  merge_r;
    logic  sext;
    size_e size;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [OP_W-1:0] op);
    op_dec_t d;
    d = '{is_load: 1'b0, is_store: 1'b0, merge_l: 1'b0, merge_r: 1'b0,
          sext: 1'b0, size: SZ_W};
    case (op)
      OP_LB:  begin d.is_load = 1'b1; d.sext = 1'b1; d.size = SZ_B; end
      OP_LBU: begin d.is_load = 1'b1; d.size = SZ_B; end
      OP_LH:  begin d.is_load = 1'b1; d.sext = 1'b1; d.size = SZ_H; end
      OP_LHU: begin d.is_load = 1'b1; d.size = SZ_H; end
      OP_LW:  d.is_load = 1'b1;
      OP_LWL: begin d.is_load = 1'b1; d.merge_l = 1'b1; end
      OP_LWR: begin d.is_load = 1'b1; d.merge_r = 1'b1; end
      OP_SB:  begin d.is_store = 1'b1; d.size = SZ_B; end
      OP_SH:  begin d.is_store = 1'b1; d.size = SZ_H; end
      OP_SW:  d.is_store = 1'b1;
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_lane_pkg::*;
(
  input  op_dec_t          dec_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misalign_o
);
  logic active;
  assign active = (dec_i.is_load | dec_i.is_store) & ~dec_i.merge_l & ~dec_i.merge_r;

  always_comb begin
    unique case (dec_i.size)
      SZ_H:    misalign_o = active & off_i[0];
      SZ_W:    misalign_o = active & (off_i != '0);
      default: misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
(
  input  op_dec_t           dec_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              misalign_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [NBYTES-1:0] be_o,
  output logic [WORD_W-1:0] data_o
);
  logic go;
  assign go = dec_i.is_store & ~misalign_i;

  // lane i (bits 8i+7:8i) holds byte offset NBYTES-1-i
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(NBYTES - 1 - i);
    logic             hit;
    logic [BYTE_W-1:0] val;
    always_comb begin
      unique case (dec_i.size)
        SZ_B: begin
          hit = (off_i == LANE_OFF);
          val = data_i[BYTE_W-1:0];
        end
        SZ_H: begin
          hit = (off_i[OFF_W-1:1] == LANE_OFF[OFF_W-1:1]);
          val = LANE_OFF[0] ? data_i[BYTE_W-1:0] : data_i[HALF_W-1:BYTE_W];
        end
        default: begin
          hit = 1'b1;
          val = data_i[BYTE_W*i +: BYTE_W];
        end
      endcase
    end
    assign be_o[i]                    = go & hit;
    assign data_o[BYTE_W*i +: BYTE_W] = dec_i.is_store ? val : '0;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
(
  input  op_dec_t           dec_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [WORD_W-1:0] mem_i,
  output logic [WORD_W-1:0] data_o
);
  logic [OFF_W-1:0]  lane_idx;
  logic [OFF_W-2:0]  half_idx;
  logic [BYTE_W-1:0] b_val;
  logic [HALF_W-1:0] h_val;

  assign lane_idx = ~off_i;
  assign half_idx = ~off_i[OFF_W-1:1];
  assign b_val    = mem_i[BYTE_W*lane_idx +: BYTE_W];
  assign h_val    = mem_i[HALF_W*half_idx +: HALF_W];

  always_comb begin
    unique case (dec_i.size)
      SZ_B:    data_o = {{(WORD_W-BYTE_W){dec_i.sext & b_val[BYTE_W-1]}}, b_val};
      SZ_H:    data_o = {{(WORD_W-HALF_W){dec_i.sext & h_val[HALF_W-1]}}, h_val};
      default: data_o = mem_i;
    endcase
  end
endmodule

// File: rtl/lsu_unaligned_merge.sv
module lsu_unaligned_merge
  import lsu_lane_pkg::*;
(
  input  logic              right_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [WORD_W-1:0] mem_i,
  input  logic [WORD_W-1:0] old_i,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [WORD_W-1:0] ONES = '1;
  logic [OFF_W-1:0]  rev_off;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] moved;

  assign rev_off = ~off_i;

  always_comb begin
    if (right_i) begin
      moved = mem_i >> (BYTE_W * rev_off);
      mask  = ONES  >> (BYTE_W * rev_off);
    end else begin
      moved = mem_i << (BYTE_W * off_i);
      mask  = ONES  << (BYTE_W * off_i);
    end
    data_o = moved | (old_i & ~mask);
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
(
  input  logic [3:0]  op_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] st_data_i,
  input  logic [31:0] mem_rdata_i,
  input  logic [31:0] rd_old_i,
  output logic [3:0]  be_o,
  output logic [31:0] st_data_o,
  output logic [31:0] ld_data_o,
  output logic        misalign_o
);
  op_dec_t           dec;
  logic [WORD_W-1:0] ext_data;
  logic [WORD_W-1:0] mrg_data;

  assign dec = decode_op(op_i);

  lsu_align_chk u_align (
    .dec_i      (dec),
    .off_i      (off_i),
    .misalign_o (misalign_o)
  );

  lsu_store_lanes u_store (
    .dec_i      (dec),
    .off_i      (off_i),
    .misalign_i (misalign_o),
    .data_i     (st_data_i),
    .be_o       (be_o),
    .data_o     (st_data_o)
  );

  lsu_load_extract u_extract (
    .dec_i  (dec),
    .off_i  (off_i),
    .mem_i  (mem_rdata_i),
    .data_o (ext_data)
  );

  lsu_unaligned_merge u_merge (
    .right_i (dec.merge_r),
    .off_i   (off_i),
    .mem_i   (mem_rdata_i),
    .old_i   (rd_old_i),
    .data_o  (mrg_data)
  );

  always_comb begin
    if (dec.merge_l | dec.merge_r)        ld_data_o = mrg_data;
    else if (dec.is_load && !misalign_o)  ld_data_o = ext_data;
    else                                  ld_data_o = '0;
  end
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
  input logic [3:0]  op_i,
  input logic [1:0]  off_i,
  input logic [31:0] st_data_i,
  input logic [31:0] mem_rdata_i,
  input logic [31:0] rd_old_i,
  input logic [3:0]  be_o,
  input logic [31:0] st_data_o,
  input logic [31:0] ld_data_o,
  input logic        misalign_o
);
  always_comb begin
    if (op_i == 4'd8)
      a_r3_byte_one_lane: assert ($countones(be_o) == 1);
    if (op_i == 4'd8)
      a_r3_byte_replicated: assert (st_data_o == {4{st_data_i[7:0]}});
    if (op_i == 4'd9 && !misalign_o)
      a_r4_half_pair: assert (be_o == 4'b1100 || be_o == 4'b0011);
    if (misalign_o)
      a_r6_no_write_on_misalign: assert (be_o == 4'b0000);
    if (op_i == 4'd5 || op_i == 4'd6)
      a_r2_merge_never_faults: assert (!misalign_o);
    if (op_i == 4'd5 && off_i == 2'd0)
      a_r10_left_full_word: assert (ld_data_o == mem_rdata_i);
    if (op_i == 4'd6 && off_i == 2'd3)
      a_r11_right_full_word: assert (ld_data_o == mem_rdata_i);
    if (op_i <= 4'd6)
      a_r12_load_no_enables: assert (be_o == 4'b0000 && st_data_o == '0);
  end
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
  .op_i        (op_i),
  .off_i       (off_i),
  .st_data_i   (st_data_i),
  .mem_rdata_i (mem_rdata_i),
  .rd_old_i    (rd_old_i),
  .be_o        (be_o),
  .st_data_o   (st_data_o),
  .ld_data_o   (ld_data_o),
  .misalign_o  (misalign_o)
);

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [1:0]  off;
  logic [31:0] st_d, mem_d, old_d;
  logic [3:0]  be;
  logic [31:0] st_q, ld_q;
  logic        mis;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit u_dut (
    .op_i(op), .off_i(off), .st_data_i(st_d), .mem_rdata_i(mem_d),
    .rd_old_i(old_d), .be_o(be), .st_data_o(st_q), .ld_data_o(ld_q),
    .misalign_o(mis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [1:0] k,
                       input logic [31:0] s, input logic [31:0] m, input logic [31:0] r);
    @(posedge clk);
    op = o; off = k; st_d = s; mem_d = m; old_d = r;
    @(negedge clk);
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] w, input int k);
    return w[8*(3-k) +: 8];
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] w, input int k, input logic [7:0] b);
    logic [31:0] r = w;
    r[8*(3-k) +: 8] = b;
    return r;
  endfunction

  task automatic t_idle();  // R1
    for (int c = 11; c < 16; c++) begin
      drive(4'(c), 2'd1, 32'hDEADBEEF, 32'h12345678, 32'hCAFEF00D);
      chk("R1 be", {28'd0, be}, 32'd0);
      chk("R1 st", st_q, 32'd0);
      chk("R1 ld", ld_q, 32'd0);
      chk("R1 mis", {31'd0, mis}, 32'd0);
    end
    drive(4'd7, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R1 ld op7", ld_q, 32'd0);
  endtask

  task automatic t_sb();  // R3
    for (int k = 0; k < 4; k++) begin
      drive(4'd8, 2'(k), 32'h11223344, 32'h0, 32'h0);
      chk("R3 be", {28'd0, be}, 32'(4'b1000 >> k));
      chk("R3 data", st_q, 32'h44444444);
      chk("R2 byte ok", {31'd0, mis}, 32'd0);
      chk("R12 ld on store", ld_q, 32'd0);
    end
  endtask

  task automatic t_sh();  // R4 R6 R2
    drive(4'd9, 2'd0, 32'hAAAA5A6B, 32'h0, 32'h0);
    chk("R4 be off0", {28'd0, be}, 32'hC);
    chk("R4 data", st_q, 32'h5A6B5A6B);
    drive(4'd9, 2'd2, 32'hAAAA5A6B, 32'h0, 32'h0);
    chk("R4 be off2", {28'd0, be}, 32'h3);
    for (int k = 1; k < 4; k += 2) begin
      drive(4'd9, 2'(k), 32'h1234, 32'h0, 32'h0);
      chk("R6 sh be", {28'd0, be}, 32'd0);
      chk("R2 sh mis", {31'd0, mis}, 32'd1);
    end
  endtask

  task automatic t_sw();  // R5 R6 R2
    drive(4'd10, 2'd0, 32'h89ABCDEF, 32'h0, 32'h0);
    chk("R5 be", {28'd0, be}, 32'hF);
    chk("R5 data", st_q, 32'h89ABCDEF);
    chk("R2 sw ok", {31'd0, mis}, 32'd0);
    for (int k = 1; k < 4; k++) begin
      drive(4'd10, 2'(k), 32'h89ABCDEF, 32'h0, 32'h0);
      chk("R6 sw be", {28'd0, be}, 32'd0);
      chk("R2 sw mis", {31'd0, mis}, 32'd1);
    end
  endtask

  task automatic t_lb();  // R7 R12
    logic [31:0] m = 32'h7F80C301;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b = byte_at(m, k);
      drive(4'd0, 2'(k), 32'hFFFF, m, 32'h0);
      chk("R7 lb", ld_q, {{24{b[7]}}, b});
      chk("R12 be", {28'd0, be}, 32'd0);
      chk("R12 st", st_q, 32'd0);
      drive(4'd1, 2'(k), 32'h0, m, 32'h0);
      chk("R7 lbu", ld_q, {24'd0, b});
    end
  endtask

  task automatic t_lh();  // R8 R9 R2
    logic [31:0] m = 32'h80017FFE;
    drive(4'd2, 2'd0, 32'h0, m, 32'h0);
    chk("R8 lh off0", ld_q, 32'hFFFF8001);
    drive(4'd2, 2'd2, 32'h0, m, 32'h0);
    chk("R8 lh off2", ld_q, 32'h00007FFE);
    drive(4'd3, 2'd0, 32'h0, m, 32'h0);
    chk("R8 lhu off0", ld_q, 32'h00008001);
    drive(4'd3, 2'd2, 32'h0, 32'h1234F00F, 32'h0);
    chk("R8 lhu off2", ld_q, 32'h0000F00F);
    drive(4'd2, 2'd1, 32'h0, m, 32'h0);
    chk("R9 lh mis data", ld_q, 32'd0);
    chk("R2 lh mis", {31'd0, mis}, 32'd1);
    drive(4'd3, 2'd3, 32'h0, m, 32'h0);
    chk("R2 lhu mis", {31'd0, mis}, 32'd1);
  endtask

  task automatic t_lw();  // R9 R2
    drive(4'd4, 2'd0, 32'h0, 32'hA5C3E7F1, 32'h0);
    chk("R9 lw", ld_q, 32'hA5C3E7F1);
    for (int k = 1; k < 4; k++) begin
      drive(4'd4, 2'(k), 32'h0, 32'hA5C3E7F1, 32'h0);
      chk("R9 lw mis data", ld_q, 32'd0);
      chk("R2 lw mis", {31'd0, mis}, 32'd1);
    end
  endtask

  task automatic t_lwl();  // R10
    logic [31:0] m = 32'h01020304, r = 32'hA1B2C3D4;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e = r;
      for (int n = 0; n < 4 - k; n++) e = put_byte(e, n, byte_at(m, k + n));
      drive(4'd5, 2'(k), 32'h0, m, r);
      chk("R10 lwl", ld_q, e);
      chk("R2 lwl nofault", {31'd0, mis}, 32'd0);
    end
  endtask

  task automatic t_lwr();  // R11
    logic [31:0] m = 32'h01020304, r = 32'hA1B2C3D4;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e = r;
      for (int n = 3 - k; n < 4; n++) e = put_byte(e, n, byte_at(m, n - (3 - k)));
      drive(4'd6, 2'(k), 32'h0, m, r);
      chk("R11 lwr", ld_q, e);
      chk("R2 lwr nofault", {31'd0, mis}, 32'd0);
    end
  endtask

  task automatic t_pair();  // R13
    logic [31:0] w0 = 32'h10203040, w1 = 32'h50607080;
    for (int k = 1; k < 4; k++) begin
      logic [31:0] e = 32'h0, step;
      for (int n = 0; n < 4; n++)
        e = put_byte(e, n, (k + n < 4) ? byte_at(w0, k + n) : byte_at(w1, k + n - 4));
      drive(4'd5, 2'(k), 32'h0, w0, 32'hEEEEEEEE);
      step = ld_q;
      drive(4'd6, 2'(k - 1), 32'h0, w1, step);
      chk("R13 pair", ld_q, e);
    end
  endtask

  initial begin
    op = 4'd15; off = '0; st_d = '0; mem_d = '0; old_d = '0;
    t_idle();
    t_sb();
    t_sh();
    t_sw();
    t_lb();
    t_lh();
    t_lw();
    t_lwl();
    t_lwr();
    t_pair();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule